// File: doc/BRIEF.md
# Alarm Status Flag Register

This block keeps the two sticky alarm flags of a real-time clock and produces the shared interrupt request for both alarms. Each alarm comparator sends it a one-cycle pulse when the time matches that alarm's setting. The pulse sets the matching flag. The flag then stays set until software clears it through the byte-wide write port.

Software reads the flags as one status byte. A flag can be cleared by writing 0 to its bit, but it can never be set from the write port. The interrupt pin is an active-low, open-drain style request. A flag pulls the pin low only when its own interrupt enable is set and the global interrupt-mode select is also set. When the pin is released, other logic outside this block may use it for another purpose.

Top module: `alarm_flag_reg`

## Requirements
- R1: The status byte carries the first alarm's flag in bit 0 and the second alarm's flag in bit 1. Bits 7 down to 2 always read 0.
- R2: A match pulse on an alarm input sets that alarm's flag at the next rising clock edge.
- R3: A write with bit 0 (or bit 1) equal to 0 clears that flag at the next edge, unless a match pulse for the same flag arrives in the same cycle.
- R4: A write with a flag bit equal to 1 leaves that flag unchanged. A write can never set a flag.
- R5: If a match pulse and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R6: A set flag stays set until a clearing write, whatever happens to later match pulses, the enables or the mode select.
- R7: `irq_n` is 0 in the same cycle whenever (flag0 AND en0) OR (flag1 AND en1) holds while `irq_mode` is 1. Otherwise it is 1.
- R8: Synchronous active-high reset clears both flags and releases `irq_n` to 1.
- R9: Written values in bits 7 down to 2 have no effect, and reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alm0_hit | input | 1 | One-cycle match pulse from the first alarm comparator |
| alm1_hit | input | 1 | One-cycle match pulse from the second alarm comparator |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data; a 0 in bit 0 or bit 1 clears that flag |
| alm0_ie | input | 1 | Interrupt enable for the first alarm |
| alm1_ie | input | 1 | Interrupt enable for the second alarm |
| irq_mode | input | 1 | Lets the flags drive the interrupt pin |
| status | output | 8 | Status byte (read port) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The flag updates (R2–R6, R8) appear one clock after the cycle that carries the pulse, the write or the reset. `status` follows the flags with no added delay. `irq_n` is combinational from the flags, the enables and the mode select, so it responds within the same cycle. The bench drives its inputs on the falling edge and compares both outputs shortly afterwards, against a model that was advanced at the preceding rising edge. This makes every comparison sample the result of the previous edge together with the current enables.

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alm0_hit,
  input  logic          alm1_hit,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic          alm0_ie,
  input  logic          alm1_ie,
  input  logic          irq_mode,
  output logic [SW-1:0] status,
  output logic          irq_n
);

  localparam int NF = 2;

  logic [NF-1:0] flag_q;
  logic [NF-1:0] hit;
  logic [NF-1:0] clr;
  logic [NF-1:0] gated;

  assign hit   = {alm1_hit, alm0_hit};
  assign clr   = {NF{wr_en}} & ~wr_data[NF-1:0];
  assign gated = flag_q & {alm1_ie, alm0_ie} & {NF{irq_mode}};

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= hit | (flag_q & ~clr);
  end

  assign status = {{(SW-NF){1'b0}}, flag_q};
  assign irq_n  = ~|gated;

  for (genvar gi = 0; gi < NF; gi++) begin : g_chk
    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      hit[gi] |=> status[gi]);
    // R3
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_data[gi] && !hit[gi]) |=> !status[gi]);
    // R4
    no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!hit[gi] && !status[gi]) |=> !status[gi]);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status[gi] && !(wr_en && !wr_data[gi])) |=> status[gi]);
  end

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_mode |-> irq_n);

  // R8
  reset_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && irq_n));

  // R9
  upper_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[SW-1:NF] != '0) |=> status[SW-1:NF] == '0);

endmodule

// File: tb/alarm_flag_reg_tb.sv
module alarm_flag_reg_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       alm0_hit = 0, alm1_hit = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       alm0_ie = 0, alm1_ie = 0, irq_mode = 0;
  logic [7:0] status;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] mf = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alarm_flag_reg u_dut (
    .clk(clk), .rst(rst), .alm0_hit(alm0_hit), .alm1_hit(alm1_hit),
    .wr_en(wr_en), .wr_data(wr_data), .alm0_ie(alm0_ie), .alm1_ie(alm1_ie),
    .irq_mode(irq_mode), .status(status), .irq_n(irq_n)
  );

  function automatic logic [1:0] next_flags(logic [1:0] f, logic [1:0] h,
                                             logic w, logic [7:0] d);
    return h | (f & ~({2{w}} & ~d[1:0]));
  endfunction

  function automatic logic exp_irq(logic [1:0] f, logic e0, logic e1, logic m);
    return !(m && ((f[0] && e0) || (f[1] && e1)));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    chk(tag, status, {6'b0, mf});
    chk("R1/R9 upper bits zero", {2'b0, status[7:2]}, 8'h00);
    chk("R7 irq_n", {7'b0, irq_n}, {7'b0, exp_irq(mf, alm0_ie, alm1_ie, irq_mode)});
  endtask

  task automatic step(logic h0, logic h1, logic w, logic [7:0] d,
                      logic e0, logic e1, logic m);
    logic [1:0] h;
    string tag;
    alm0_hit = h0; alm1_hit = h1; wr_en = w; wr_data = d;
    alm0_ie = e0; alm1_ie = e1; irq_mode = m;
    #1 check_outs("R7/R1 flags before edge");
    h = {h1, h0};
    if (w && |(h & ~d[1:0]))                      tag = "R5 set wins over clear";
    else if (|h)                                  tag = "R2 match sets flag";
    else if (w && |(mf & ~d[1:0]))                tag = "R3 write 0 clears";
    else if (w)                                   tag = "R4/R9 write ones ignored";
    else                                          tag = "R6 flags sticky";
    @(posedge clk);
    mf = next_flags(mf, h, w, d);
    @(negedge clk);
    alm0_hit = 0; alm1_hit = 0; wr_en = 0;
    #1 chk(tag, status, {6'b0, mf});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1375));
    irq_mode = 1; alm0_ie = 1; alm1_ie = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check_outs("R8 reset state");
    rst = 0;
    // directed
    step(1, 0, 0, 8'h00, 1, 1, 1);   // R2 set flag0
    step(0, 0, 1, 8'hFF, 1, 1, 1);   // R4 ones ignored
    step(0, 0, 1, 8'hFC, 1, 1, 1);   // R9 upper bits ignored and R3 clear both
    step(0, 1, 1, 8'h00, 1, 1, 1);   // R5 collision
    step(0, 0, 0, 8'h00, 0, 0, 1);   // R6 mask enables, flag stays
    step(0, 0, 0, 8'h00, 1, 1, 0);   // R7 mode off releases pin
    step(1, 0, 0, 8'h00, 0, 1, 1);   // R7 flag0 masked, flag1 drives
    step(0, 0, 1, 8'hFD, 1, 1, 1);   // R3 clear flag1 only
    // reset mid-run: R8
    @(negedge clk); rst = 1;
    @(posedge clk); mf = 0;
    @(negedge clk);
    #1 check_outs("R8 reset clears flags");
    rst = 0;
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3], r[4], r[15:8], r[5], r[6], r[7] | r[16]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule